// File: doc/BRIEF.md
# Warp memory access coalescer

The block takes one memory instruction issued for a whole warp of 32 lanes and turns it into a stream of naturally aligned segment transactions for the memory system. Each lane carries an active bit and a byte address. The lanes share a word-size code, a caching-mode bit and a store bit. Each outgoing transaction names the base address of one segment, the size of that segment in bytes, and the mask of lanes whose accesses it serves.

The caching mode sets the segment size. When data is kept in both cache levels, segments are 128-byte lines. When data is kept in the second level only, segments are 32-byte sectors. Wide words first split the warp into independent sub-warp requests: halves for 8-byte words and quarters for 16-byte words. Inside each request, all active lanes that fall in one segment share a single transaction. For stores, lanes that write an identical address collapse to one writer.

An instruction is presented on `inValid` and is taken at the first clock edge where the block is idle. Transactions then leave through a valid/ready handshake at one per cycle. `txLast` marks the final transaction and `txCount` counts the transactions handed off so far.

Top module: `warp_coalescer`

## Requirements
- R1: `txBase` is always a multiple of `txSize`. `txSize` is 128 when `inCacheBoth`=1 was latched and 32 when `inCacheBoth`=0 was latched.
- R2: `txBase` is the leading lane's address with its low bits (7 or 5 bits) cleared. `txMask` holds exactly the unserviced active lanes of the current request whose address lies in that segment.
- R3: `inWordSize` code 0 (4-byte words) forms one request from lanes 0-31. Code 1 (8-byte words) forms two requests: lanes 0-15, then lanes 16-31. Code 2 (16-byte words) forms four requests of 8 lanes each, in ascending order. Code 3 is treated as code 2. Lanes of different requests never share a transaction, even when they touch the same segment.
- R4: The leading lane of each transaction is the lowest-numbered active lane not yet serviced. In `txMask`, bit i stands for lane i.
- R5: For loads (`inStore`=0), lanes with identical or overlapping addresses all appear in the mask of a single shared transaction.
- R6: For stores (`inStore`=1), when several active lanes hold the same address, only the highest-numbered of them appears in any transaction mask.
- R7: `busy` is high from the cycle after an instruction with at least one serviced lane is accepted, until the edge where its last transaction is handed off. `txValid` equals `busy`. `inValid` has no effect while `busy` is high.
- R8: An accepted instruction with no active lanes emits no transaction, leaves `busy` low and sets `txCount` to 0.
- R9: `txLast` is high only on the final transaction of an instruction. `txCount` is cleared on acceptance and rises by one on each handshake (`txValid` and `txReady` high at an edge).
- R10: While `txValid` is high and `txReady` is low, `txBase`, `txSize`, `txMask` and `txLast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction present; taken when not busy |
| inActive | input | 32 | Per-lane active bits |
| inAddr | input | 1024 | Per-lane byte addresses, lane i at bits [32i+31:32i] |
| inWordSize | input | 2 | 0: 4-byte, 1: 8-byte, 2/3: 16-byte words |
| inCacheBoth | input | 1 | 1: 128-byte lines, 0: 32-byte sectors |
| inStore | input | 1 | 1: non-atomic store, 0: load |
| busy | output | 1 | Instruction in progress |
| txValid | output | 1 | Transaction available |
| txReady | input | 1 | Consumer takes the transaction |
| txBase | output | 32 | Segment base address |
| txSize | output | 8 | Segment size in bytes |
| txMask | output | 32 | Lanes served by this transaction |
| txLast | output | 1 | Final transaction of the instruction |
| txCount | output | 6 | Transactions handed off since acceptance |

## Verification
The hardest case to reach from the ports is lanes from different sub-warp requests landing in one segment, because their masks must stay separate and must still come out in ascending request order. The stimulus aims sixteen-byte accesses from every lane at one address and aims eight-byte strides across a line boundary. Store collapsing interacts with segment merging, so store instructions with deliberate address collisions and partly inactive lanes are issued under random back-pressure. A reference model written as queues checks every cycle.

// File: rtl/coalescer_pkg.sv
package coalescer_pkg;

  typedef enum logic [1:0] {
    WORD4  = 2'd0,
    WORD8  = 2'd1,
    WORD16 = 2'd2,
    WORDX  = 2'd3
  } wordSize_e;

  typedef struct packed {
    logic load;
    logic retire;
  } ctrlStrobes_t;

endpackage

// File: rtl/coalescer_control.sv
module coalescer_control
  import coalescer_pkg::*;
#(
  parameter int NUM_LANES = 32,
  localparam int CNT_W = $clog2(NUM_LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             pendingAny,
  input  logic             txReady,
  output ctrlStrobes_t     strobes,
  output logic             busy,
  output logic             txValid,
  output logic [CNT_W-1:0] txCount
);

  assign busy           = pendingAny;
  assign txValid        = pendingAny;
  assign strobes.load   = inValid && !pendingAny;
  assign strobes.retire = pendingAny && txReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCount <= '0;
    end else if (strobes.load) begin
      txCount <= '0;
    end else if (strobes.retire) begin
      txCount <= txCount + 1'b1;
    end
  end

  // R7: a stalled transaction keeps the block busy
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !txReady) |=> busy);

  // R9: one instruction never emits more transactions than lanes
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(NUM_LANES));

endmodule

// File: rtl/coalescer_datapath.sv
module coalescer_datapath
  import coalescer_pkg::*;
#(
  parameter int NUM_LANES    = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  localparam int LANE_IDX_W  = $clog2(NUM_LANES),
  localparam int SIZE_W      = $clog2(LINE_BYTES) + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [NUM_LANES-1:0]        inActive,
  input  logic [NUM_LANES*ADDR_W-1:0] inAddr,
  input  logic [1:0]                  inWordSize,
  input  logic                        inCacheBoth,
  input  logic                        inStore,
  output logic                        pendingAny,
  output logic [ADDR_W-1:0]           txBase,
  output logic [SIZE_W-1:0]           txSize,
  output logic [NUM_LANES-1:0]        txMask,
  output logic                        txLast
);

  logic [ADDR_W-1:0]     laneIn [NUM_LANES];
  logic [ADDR_W-1:0]     addrR  [NUM_LANES];
  logic [NUM_LANES-1:0]  dupAbove;
  logic [NUM_LANES-1:0]  keepMask;
  logic [NUM_LANES-1:0]  pendMask;
  logic [1:0]            wsR;
  logic                  cacheBothR;
  logic [LANE_IDX_W-1:0] leadIdx;
  logic [ADDR_W-1:0]     segMask;
  logic [ADDR_W-1:0]     leadSeg;
  int                    grpShift;

  // unpack lane addresses
  for (genvar g = 0; g < NUM_LANES; g++) begin : gUnpack
    assign laneIn[g] = inAddr[g*ADDR_W +: ADDR_W];
  end

  // store collapsing: a lane survives only if no higher active lane writes its address
  always_comb begin
    dupAbove = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      for (int j = i + 1; j < NUM_LANES; j++) begin
        if (inActive[j] && (laneIn[j] == laneIn[i])) dupAbove[i] = 1'b1;
      end
    end
    keepMask = inActive & ~(inStore ? dupAbove : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask   <= '0;
      wsR        <= WORD4;
      cacheBothR <= 1'b0;
      for (int i = 0; i < NUM_LANES; i++) addrR[i] <= '0;
    end else if (strobes.load) begin
      pendMask   <= keepMask;
      wsR        <= (inWordSize == WORDX) ? WORD16 : inWordSize;
      cacheBothR <= inCacheBoth;
      for (int i = 0; i < NUM_LANES; i++) addrR[i] <= laneIn[i];
    end else if (strobes.retire) begin
      pendMask <= pendMask & ~txMask;
    end
  end

  // lowest pending lane leads; it always lies in the earliest non-empty request
  always_comb begin
    leadIdx = '0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (pendMask[i]) leadIdx = LANE_IDX_W'(i);
    end
  end

  assign segMask  = cacheBothR ? ~ADDR_W'(LINE_BYTES - 1) : ~ADDR_W'(SECTOR_BYTES - 1);
  assign leadSeg  = addrR[leadIdx] & segMask;
  assign grpShift = LANE_IDX_W - int'(wsR);

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      txMask[i] = pendMask[i]
               && ((LANE_IDX_W'(i) >> grpShift) == (leadIdx >> grpShift))
               && ((addrR[i] & segMask) == leadSeg);
    end
  end

  assign pendingAny = |pendMask;
  assign txBase     = leadSeg;
  assign txSize     = cacheBothR ? SIZE_W'(LINE_BYTES) : SIZE_W'(SECTOR_BYTES);
  assign txLast     = (pendMask & ~txMask) == '0;

  // lane span of the leading request, built arithmetically for checking
  int                   lanesPerGrp;
  logic [NUM_LANES-1:0] grpLanes;
  assign lanesPerGrp = NUM_LANES >> wsR;
  assign grpLanes    = ((NUM_LANES'(1) << lanesPerGrp) - NUM_LANES'(1))
                       << ((int'(leadIdx) / lanesPerGrp) * lanesPerGrp);

  // R1: emitted base aligned to emitted size
  assert_base_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny |-> ((txBase & ADDR_W'(txSize - 1'b1)) == '0));

  // R2: the mask is non-empty and only names lanes still pending
  assert_mask_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny |-> ((txMask != '0) && ((txMask & ~pendMask) == '0)));

  // R3: a transaction never spans two sub-warp requests
  assert_single_group_R3: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny |-> ((txMask & ~grpLanes) == '0));

  // R4: lowest set bit of the mask equals lowest pending lane
  assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny |-> ((txMask & (~txMask + 1'b1)) == (pendMask & (~pendMask + 1'b1))));

  // R9: handing off the last transaction empties the block
  assert_last_drains_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.retire && txLast) |=> !pendingAny);

  // R10: stalled output holds steady
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pendingAny && !strobes.retire) |=> ($stable(txBase) && $stable(txMask) && $stable(txSize)));

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coalescer_pkg::*;
#(
  parameter int NUM_LANES    = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  localparam int SIZE_W      = $clog2(LINE_BYTES) + 1,
  localparam int CNT_W       = $clog2(NUM_LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [NUM_LANES-1:0]        inActive,
  input  logic [NUM_LANES*ADDR_W-1:0] inAddr,
  input  logic [1:0]                  inWordSize,
  input  logic                        inCacheBoth,
  input  logic                        inStore,
  output logic                        busy,
  output logic                        txValid,
  input  logic                        txReady,
  output logic [ADDR_W-1:0]           txBase,
  output logic [SIZE_W-1:0]           txSize,
  output logic [NUM_LANES-1:0]        txMask,
  output logic                        txLast,
  output logic [CNT_W-1:0]            txCount
);

  ctrlStrobes_t strobes;
  logic         pendingAny;

  coalescer_control #(.NUM_LANES(NUM_LANES)) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .pendingAny (pendingAny),
    .txReady    (txReady),
    .strobes    (strobes),
    .busy       (busy),
    .txValid    (txValid),
    .txCount    (txCount)
  );

  coalescer_datapath #(
    .NUM_LANES    (NUM_LANES),
    .ADDR_W       (ADDR_W),
    .LINE_BYTES   (LINE_BYTES),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .inActive    (inActive),
    .inAddr      (inAddr),
    .inWordSize  (inWordSize),
    .inCacheBoth (inCacheBoth),
    .inStore     (inStore),
    .pendingAny  (pendingAny),
    .txBase      (txBase),
    .txSize      (txSize),
    .txMask      (txMask),
    .txLast      (txLast)
  );

endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [31:0]   inActive = '0;
  logic [1023:0] inAddr = '0;
  logic [1:0]    inWordSize = '0;
  logic          inCacheBoth = 1'b0;
  logic          inStore = 1'b0;
  logic          txReady = 1'b0;
  logic          busy, txValid, txLast;
  logic [31:0]   txBase, txMask;
  logic [7:0]    txSize;
  logic [5:0]    txCount;

  warp_coalescer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inActive(inActive), .inAddr(inAddr),
    .inWordSize(inWordSize), .inCacheBoth(inCacheBoth), .inStore(inStore),
    .busy(busy), .txValid(txValid), .txReady(txReady), .txBase(txBase),
    .txSize(txSize), .txMask(txMask), .txLast(txLast), .txCount(txCount)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0] qBase[$];
  logic [31:0] qMask[$];
  int          qSize[$];
  bit          qLast[$];
  logic [31:0] obsBase[$];
  logic [31:0] obsMask[$];
  int          expCount = 0;
  bit          popNext = 0;
  bit          loadNext = 0;
  logic [31:0] drvAddr[32];
  logic [31:0] mAddr[32];
  logic [31:0] mAct;
  int          mWs;
  bit          mCb, mSt;
  logic [31:0] seenBase, seenMask;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic buildModel();
    logic [31:0] pend;
    int grpLanes, segBytes;
    pend = mAct;
    if (mSt) begin
      for (int i = 0; i < 32; i++)
        for (int j = i + 1; j < 32; j++)
          if (mAct[j] && mAddr[j] == mAddr[i]) pend[i] = 1'b0;
    end
    grpLanes = (mWs == 0) ? 32 : (mWs == 1) ? 16 : 8;
    segBytes = mCb ? 128 : 32;
    while (pend != 0) begin
      int lead;
      logic [31:0] seg, msk;
      lead = 0;
      while (!pend[lead]) lead++;
      seg = mAddr[lead] - (mAddr[lead] % segBytes);
      msk = '0;
      for (int j = 0; j < 32; j++)
        if (pend[j] && (j / grpLanes) == (lead / grpLanes) &&
            (mAddr[j] - (mAddr[j] % segBytes)) == seg) msk[j] = 1'b1;
      pend = pend & ~msk;
      qBase.push_back(seg);
      qMask.push_back(msk);
      qSize.push_back(segBytes);
      qLast.push_back(pend == 0);
    end
  endtask

  task automatic compare();
    bit expBusy;
    expBusy = (qBase.size() != 0);
    check(busy == expBusy, "R7", "busy", busy, expBusy);
    check(txValid == expBusy, "R7", "txValid", txValid, expBusy);
    check(txCount == expCount, "R9", "txCount", txCount, expCount);
    if (expBusy && txValid) begin
      check(txBase == qBase[0], "R2", "txBase", txBase, qBase[0]);
      check(txSize == qSize[0], "R1", "txSize", txSize, qSize[0]);
      check(txMask == qMask[0], "R4", "txMask", txMask, qMask[0]);
      check(txLast == qLast[0], "R9", "txLast", txLast, qLast[0]);
    end
    seenBase = txBase;
    seenMask = txMask;
  endtask

  task automatic tick();
    @(posedge clk);
    if (popNext) begin
      obsBase.push_back(seenBase);
      obsMask.push_back(seenMask);
      void'(qBase.pop_front()); void'(qMask.pop_front());
      void'(qSize.pop_front()); void'(qLast.pop_front());
      expCount++;
    end
    if (loadNext) begin
      expCount = 0;
      buildModel();
    end
    popNext = 0;
    loadNext = 0;
    @(negedge clk);
    compare();
  endtask

  task automatic packAddr();
    for (int i = 0; i < 32; i++) inAddr[i*32 +: 32] = drvAddr[i];
  endtask

  task automatic issue(logic [31:0] act, int ws, bit cb, bit st, bit randReady, bit poke);
    int pokeLeft;
    obsBase.delete();
    obsMask.delete();
    packAddr();
    inActive = act; inWordSize = 2'(ws); inCacheBoth = cb; inStore = st;
    inValid = 1'b1;
    loadNext = (qBase.size() == 0);
    mAct = act; mWs = (ws == 3) ? 2 : ws; mCb = cb; mSt = st;
    for (int i = 0; i < 32; i++) mAddr[i] = drvAddr[i];
    txReady = 1'b0;
    tick();
    inValid = 1'b0;
    pokeLeft = poke ? 3 : 0;
    while (qBase.size() != 0) begin
      if (pokeLeft > 0) begin
        // R7: a second instruction offered while busy must be ignored
        inValid = 1'b1;
        inActive = '1;
        for (int i = 0; i < 32; i++) inAddr[i*32 +: 32] = 32'h9000 + 32'(i * 256);
        pokeLeft--;
      end else begin
        inValid = 1'b0;
      end
      txReady = randReady ? 1'($urandom_range(0, 1)) : 1'b1;
      popNext = txReady;
      loadNext = 1'b0;
      tick();
    end
    inValid = 1'b0;
    txReady = 1'($urandom_range(0, 1));
    tick();
  endtask

  task automatic checkObs(int idx, logic [31:0] b, logic [31:0] m, string tag);
    check(obsMask.size() > idx, tag, "tx present", obsMask.size(), idx + 1);
    if (obsMask.size() > idx) begin
      check(obsBase[idx] == b, tag, "base", obsBase[idx], b);
      check(obsMask[idx] == m, tag, "mask", obsMask[idx], m);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // reset state
    check(busy == 1'b0, "R7", "reset busy", busy, 0);
    check(txValid == 1'b0, "R7", "reset txValid", txValid, 0);
    check(txCount == 0, "R9", "reset txCount", txCount, 0);

    // R1: unit stride 4-byte, 128-byte lines -> one transaction
    for (int i = 0; i < 32; i++) drvAddr[i] = 32'h1000 + 32'(4 * i);
    issue('1, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(obsMask.size() == 1, "R1", "count line mode", obsMask.size(), 1);
    checkObs(0, 32'h1000, 32'hFFFF_FFFF, "R1");

    // R1: same stride, 32-byte sectors -> four transactions
    issue('1, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(obsMask.size() == 4, "R1", "count sector mode", obsMask.size(), 4);
    checkObs(3, 32'h1060, 32'hFF00_0000, "R1");

    // R3: 8-byte stride splits into halves
    for (int i = 0; i < 32; i++) drvAddr[i] = 32'h2000 + 32'(8 * i);
    issue('1, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    checkObs(0, 32'h2000, 32'h0000_FFFF, "R3");
    checkObs(1, 32'h2080, 32'hFFFF_0000, "R3");

    // R3: 16-byte words, all lanes one address -> four separate quarters
    for (int i = 0; i < 32; i++) drvAddr[i] = 32'h3000;
    issue('1, 2, 1'b1, 1'b0, 1'b1, 1'b0);
    check(obsMask.size() == 4, "R3", "quarter count", obsMask.size(), 4);
    checkObs(2, 32'h3000, 32'h00FF_0000, "R3");

    // R5: load, identical addresses share one transaction
    for (int i = 0; i < 32; i++) drvAddr[i] = 32'h5004;
    issue(32'h0000_FFFF, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(obsMask.size() == 1, "R5", "shared count", obsMask.size(), 1);
    checkObs(0, 32'h5000, 32'h0000_FFFF, "R5");

    // R6: store, identical addresses collapse to highest active lane
    issue(32'h0000_FFFF, 0, 1'b0, 1'b1, 1'b1, 1'b0);
    checkObs(0, 32'h5000, 32'h0000_8000, "R6");
    issue(32'h7FFF_FFFF, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    checkObs(0, 32'h5000, 32'h4000_0000, "R6");

    // R4: reversed addresses, lowest lane leads each transaction
    for (int i = 0; i < 32; i++) drvAddr[i] = 32'h4000 + 32'((31 - i) * 32);
    issue('1, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    checkObs(0, 32'h43E0, 32'h0000_0001, "R4");
    checkObs(31, 32'h4000, 32'h8000_0000, "R4");

    // R8: no active lanes
    issue('0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(obsMask.size() == 0, "R8", "no tx", obsMask.size(), 0);
    check(busy == 1'b0 && txValid == 1'b0, "R8", "idle", {busy, txValid}, 0);
    check(txCount == 0, "R8", "count zero", txCount, 0);

    // R7: offered instruction while busy is ignored; R10 under back-pressure
    for (int i = 0; i < 32; i++) drvAddr[i] = 32'(i * 40);
    issue('1, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    check(obsMask.size() == 32, "R7", "only first instr", obsMask.size(), 32);

    // R10 and mixed patterns: random instructions with collisions
    for (int n = 0; n < 60; n++) begin
      int ws;
      ws = $urandom_range(0, 3);
      for (int i = 0; i < 32; i++) drvAddr[i] = 32'($urandom_range(0, 63) * 16);
      issue($urandom(), ws, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule